// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits in an HDLC receive path, after the deframer and ahead of the receive FIFO. It watches the leading address bytes of each incoming frame and decides whether the frame is written into the FIFO or discarded. Bytes arrive with a start strobe on the first byte of a frame and an end strobe on the last byte. The block drives the FIFO write strobe, the data byte and an end-of-frame tag. A rejected frame never produces a write, and neither does any part of it.

The first address byte is checked against a programmed address of six or seven bits. The second address byte is checked against its own seven-bit address. Each of these checks has its own enable. An all-call address of seven ones in the first byte is accepted whatever the programmed values are, provided both enables are set. When recognition is switched off as a whole, every frame passes through unchanged. A first byte that must wait for the second-byte decision is held in a one-byte register. When the frame is accepted, that byte is written, followed on the next cycle by the second byte.

Input bytes must be spaced at least one idle cycle apart. A bit-serial deframer always meets this rule, and it leaves room for the extra cycle needed to write a held byte.

Top module: `hdlc_rx_addr_filter`

States: `ST_IDLE` (waiting for a start byte), `ST_HOLD` (first byte held, waiting for the second), `ST_FLUSH` (writing the second byte after the held first byte), `ST_PASS` (frame accepted, bytes forwarded), `ST_DROP` (frame rejected, bytes discarded). Transitions: a start byte from any state except `ST_FLUSH` is evaluated anew and goes to `ST_PASS`, `ST_DROP` or `ST_HOLD`, or to `ST_IDLE` if it also ends the frame. `ST_HOLD` goes to `ST_FLUSH` on a second-byte match and to `ST_DROP` on a mismatch. `ST_FLUSH` goes to `ST_PASS`, or to `ST_IDLE` if the second byte ended the frame. `ST_PASS` and `ST_DROP` return to `ST_IDLE` on the end byte.

## Requirements
- R1: After reset, and with no input, no write is made. Every write follows, one cycle later, an input byte or the flush of a held byte.
- R2: With `cfg_filt_en` low, every byte of every frame is written one cycle after it arrives, with `wr_last` set on the end byte only.
- R3: In six-bit mode (`cfg_wide_a1` low), the first byte passes when its bits 7..2 equal `cfg_a1_addr[6:1]`. Bits 1 and 0 of the byte are not compared.
- R4: In seven-bit mode (`cfg_wide_a1` high), the first byte passes only when its bits 7..1 equal `cfg_a1_addr[6:0]`.
- R5: With `cfg_a1_en` low, the first byte passes whatever its value.
- R6: With `cfg_a2_en` high, the second byte passes only when its bits 7..1 equal `cfg_a2_addr`. With `cfg_a2_en` low, the second byte is not examined, and the frame is accepted on the first byte alone.
- R7: A frame that fails any enabled comparison produces no write for any of its bytes.
- R8: A first byte whose bits 7..1 are all ones (0xFE or 0xFF) is accepted whatever the programmed addresses are, when both `cfg_a1_en` and `cfg_a2_en` are high. The decision is made on that single byte, so a one-byte frame is accepted and any second byte is not examined.
- R9: If either enable is low, an all-ones first byte gets no special treatment and is compared in the normal way.
- R10: When a frame is accepted on its second byte, the held first byte is written at the second byte's arrival plus one cycle, and the second byte is written on the cycle after that. The rest of the frame follows in order, so no partial frame is ever written.
- R11: With recognition enabled and `cfg_a2_en` high, a frame that ends on a first byte that passes, but is not all-call, is rejected.
- R12: A start byte that arrives while a first byte is held discards the held byte and starts a new evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte strobe from the deframer |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| cfg_filt_en | input | 1 | Global address recognition enable |
| cfg_wide_a1 | input | 1 | First-byte compare is seven bits wide when high, six bits when low |
| cfg_a1_en | input | 1 | First-byte compare enable |
| cfg_a1_addr | input | 7 | First-byte address (bit 6 is MSB; bit 0 used only in seven-bit mode) |
| cfg_a2_en | input | 1 | Second-byte compare enable |
| cfg_a2_addr | input | 7 | Second-byte address (bit 6 is MSB) |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | 8 | Byte written to the FIFO |
| wr_last | output | 1 | End-of-frame tag for the written byte |

## Verification
The assertions check several properties on every cycle:
- a write always has a cause one cycle back;
- the drop state stays silent;
- the flush state is always bracketed by two consecutive writes;
- an end-tagged write returns the machine to idle;
- a bypassed or all-call start byte is written on the next cycle;
- the deframer keeps its byte spacing.

Some behaviour only the directed scenarios can show:
- which byte values pass each compare width;
- that the second byte is ignored when its enable is low;
- that short frames and aborted held frames leave nothing in the FIFO;
- that accepted frames arrive complete and in order.

// File: rtl/haf_pkg.sv
package haf_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_FLUSH,
        ST_PASS,
        ST_DROP
    } haf_state_t;

endpackage

// File: rtl/haf_addr_match.sv
module haf_addr_match #(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] addr_field,
    input  logic              cfg_wide,
    input  logic              a1_en,
    input  logic [ADDR_W-1:0] a1_addr,
    input  logic              a2_en,
    input  logic [ADDR_W-1:0] a2_addr,
    output logic              hit1,
    output logic              hit2,
    output logic              allcall
);

    logic [ADDR_W-1:0] cmp_mask;

    // the lowest address bit takes part only in the wide compare
    for (genvar g = 0; g < ADDR_W; g++) begin : g_mask
        if (g == 0) begin : g_lsb
            assign cmp_mask[g] = cfg_wide;
        end else begin : g_hi
            assign cmp_mask[g] = 1'b1;
        end
    end

    always_comb begin
        hit1    = !a1_en || (((addr_field ^ a1_addr) & cmp_mask) == '0);
        hit2    = !a2_en || (addr_field == a2_addr);
        allcall = a1_en && a2_en && (&addr_field);
    end

endmodule

// File: rtl/haf_byte_hold.sv
module haf_byte_hold #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] d_in,
    input  logic              last_in,
    output logic [BYTE_W-1:0] q,
    output logic              last_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            last_q <= 1'b0;
        end else if (load) begin
            q      <= d_in;
            last_q <= last_in;
        end
    end

endmodule

// File: rtl/hdlc_rx_addr_filter.sv
module hdlc_rx_addr_filter #(
    parameter int BYTE_W = haf_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              cfg_filt_en,
    input  logic              cfg_wide_a1,
    input  logic              cfg_a1_en,
    input  logic [BYTE_W-2:0] cfg_a1_addr,
    input  logic              cfg_a2_en,
    input  logic [BYTE_W-2:0] cfg_a2_addr,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_last
);
    import haf_pkg::*;

    localparam int ADDR_W = BYTE_W - 1;

    haf_state_t        state, state_n;
    logic              hit1, hit2, allcall;
    logic              start, mid;
    logic              emit_cur, emit_held, load_hold;
    logic [BYTE_W-1:0] held_data;
    logic              held_last;

    haf_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .addr_field (in_data[BYTE_W-1:1]),
        .cfg_wide   (cfg_wide_a1),
        .a1_en      (cfg_a1_en),
        .a1_addr    (cfg_a1_addr),
        .a2_en      (cfg_a2_en),
        .a2_addr    (cfg_a2_addr),
        .hit1       (hit1),
        .hit2       (hit2),
        .allcall    (allcall)
    );

    haf_byte_hold #(.BYTE_W(BYTE_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_hold),
        .d_in    (in_data),
        .last_in (in_eof),
        .q       (held_data),
        .last_q  (held_last)
    );

    assign start = in_valid && in_sof;
    assign mid   = in_valid && !in_sof;

    // next-state and datapath control
    always_comb begin
        state_n   = state;
        emit_cur  = 1'b0;
        emit_held = 1'b0;
        load_hold = 1'b0;
        if (state == ST_FLUSH) begin
            emit_held = 1'b1;
            state_n   = held_last ? ST_IDLE : ST_PASS;
        end else if (start) begin
            if (!cfg_filt_en || allcall || (hit1 && !cfg_a2_en)) begin
                emit_cur = 1'b1;
                state_n  = in_eof ? ST_IDLE : ST_PASS;
            end else if (!hit1) begin
                state_n  = in_eof ? ST_IDLE : ST_DROP;
            end else if (in_eof) begin
                state_n  = ST_IDLE;
            end else begin
                load_hold = 1'b1;
                state_n   = ST_HOLD;
            end
        end else if (mid) begin
            unique case (state)
                ST_IDLE: begin
                    state_n = ST_IDLE;
                end
                ST_PASS: begin
                    emit_cur = 1'b1;
                    state_n  = in_eof ? ST_IDLE : ST_PASS;
                end
                ST_DROP: begin
                    state_n = in_eof ? ST_IDLE : ST_DROP;
                end
                ST_HOLD: begin
                    if (hit2) begin
                        emit_held = 1'b1;
                        load_hold = 1'b1;
                        state_n   = ST_FLUSH;
                    end else begin
                        state_n = in_eof ? ST_IDLE : ST_DROP;
                    end
                end
                default: begin
                    state_n = ST_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // registered FIFO write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_data <= '0;
            wr_last <= 1'b0;
        end else begin
            wr_en <= emit_cur || emit_held;
            if (emit_held) begin
                wr_data <= held_data;
                wr_last <= held_last;
            end else if (emit_cur) begin
                wr_data <= in_data;
                wr_last <= in_eof;
            end
        end
    end

endmodule

// File: rtl/hdlc_rx_addr_filter_chk.sv
module hdlc_rx_addr_filter_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [BYTE_W-1:0] in_data,
    input logic              in_sof,
    input logic              cfg_filt_en,
    input logic              cfg_a1_en,
    input logic              cfg_a2_en,
    input logic              wr_en,
    input logic              wr_last,
    input haf_pkg::haf_state_t state
);
    import haf_pkg::*;

    AST_WRITE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(in_valid) || $past(state) == ST_FLUSH)); // R1

    AST_BYPASS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_filt_en && in_valid && in_sof) |=> wr_en); // R2

    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DROP && !(in_valid && in_sof)) |=> !wr_en); // R7

    AST_ALLCALL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_filt_en && cfg_a1_en && cfg_a2_en && in_valid && in_sof
         && (&in_data[BYTE_W-1:1])) |=> wr_en); // R8

    AST_FLUSH_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH) |-> (wr_en && !wr_last)); // R10

    AST_FLUSH_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH) |=> wr_en); // R10

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_last) |-> (state == ST_IDLE)); // R10

    AST_IN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> !in_valid); // R10

endmodule

bind hdlc_rx_addr_filter hdlc_rx_addr_filter_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_sof      (in_sof),
    .cfg_filt_en (cfg_filt_en),
    .cfg_a1_en   (cfg_a1_en),
    .cfg_a2_en   (cfg_a2_en),
    .wr_en       (wr_en),
    .wr_last     (wr_last),
    .state       (state)
);

// File: tb/hdlc_rx_addr_filter_test.sv
module hdlc_rx_addr_filter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic       cfg_filt_en = 1'b0;
    logic       cfg_wide_a1 = 1'b0;
    logic       cfg_a1_en = 1'b0;
    logic [6:0] cfg_a1_addr = '0;
    logic       cfg_a2_en = 1'b0;
    logic [6:0] cfg_a2_addr = '0;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       wr_last;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ncap = 0;
    logic [8:0] cap [0:31];
    int cap_cyc [0:31];
    logic [7:0] tx [0:15];

    always #5 clk = ~clk;

    hdlc_rx_addr_filter uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .cfg_filt_en(cfg_filt_en),
        .cfg_wide_a1(cfg_wide_a1), .cfg_a1_en(cfg_a1_en), .cfg_a1_addr(cfg_a1_addr),
        .cfg_a2_en(cfg_a2_en), .cfg_a2_addr(cfg_a2_addr),
        .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (wr_en && ncap < 32) begin
            cap[ncap]     = {wr_last, wr_data};
            cap_cyc[ncap] = cyc;
            ncap          = ncap + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] d, input logic sof, input logic eof);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sof = sof; in_eof = eof;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    // sends tx[0..n-1] as one frame; checks count and content of writes
    task automatic run_frame(input string req, input int n, input bit keep);
        for (int i = 0; i < n; i++) send_byte(tx[i], i == 0, i == n - 1);
        repeat (4) @(negedge clk);
        check(req, ncap, keep ? n : 0);
        if (keep && ncap == n) begin
            for (int i = 0; i < n; i++)
                check(req, {23'd0, cap[i]}, {23'd0, (i == n - 1), tx[i]});
        end
    endtask

    task automatic clear_cap();
        @(negedge clk);
        ncap = 0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle after reset", {31'd0, wr_en}, 0);
        check("R1 no writes", ncap, 0);
    endtask

    task automatic t_bypass();
        cfg_filt_en = 1'b0; cfg_a1_en = 1'b1; cfg_a2_en = 1'b1;
        cfg_a1_addr = 7'h11; cfg_a2_addr = 7'h22;
        clear_cap();
        tx[0] = 8'h3C; tx[1] = 8'h99; tx[2] = 8'h01;
        run_frame("R2 bypass", 3, 1'b1);
    endtask

    task automatic t_six_bit();
        cfg_filt_en = 1'b1; cfg_wide_a1 = 1'b0; cfg_a1_en = 1'b1; cfg_a2_en = 1'b0;
        cfg_a1_addr = 7'b1010110;
        clear_cap();
        tx[0] = 8'hAF; tx[1] = 8'h11; tx[2] = 8'h22;
        run_frame("R3 six-bit match bits1..0 free, R6 second byte ignored", 3, 1'b1);
        clear_cap();
        tx[0] = 8'hB0; tx[1] = 8'h11;
        run_frame("R3 six-bit mismatch R7", 2, 1'b0);
    endtask

    task automatic t_seven_bit();
        cfg_wide_a1 = 1'b1;
        clear_cap();
        tx[0] = 8'hAE; tx[1] = 8'h44;
        run_frame("R4 seven-bit bit1 differs", 2, 1'b0);
        clear_cap();
        tx[0] = 8'hAD; tx[1] = 8'h44;
        run_frame("R4 seven-bit match", 2, 1'b1);
        cfg_wide_a1 = 1'b0;
    endtask

    task automatic t_a1_off();
        cfg_a1_en = 1'b0; cfg_a2_en = 1'b0;
        clear_cap();
        tx[0] = 8'h00; tx[1] = 8'h5A;
        run_frame("R5 first enable low", 2, 1'b1);
        cfg_a1_en = 1'b1;
    endtask

    task automatic t_second_byte();
        cfg_a2_en = 1'b1; cfg_a2_addr = 7'h35;
        clear_cap();
        tx[0] = 8'hAC; tx[1] = 8'h6B; tx[2] = 8'h01; tx[3] = 8'hF0;
        run_frame("R6 second byte match R10 order", 4, 1'b1);
        if (ncap >= 2) check("R10 back-to-back head", cap_cyc[1] - cap_cyc[0], 1);
        clear_cap();
        tx[0] = 8'hAC; tx[1] = 8'h6C; tx[2] = 8'h01;
        run_frame("R6 second byte mismatch R7", 3, 1'b0);
    endtask

    task automatic t_allcall();
        cfg_a1_en = 1'b1; cfg_a2_en = 1'b1;
        clear_cap();
        tx[0] = 8'hFF;
        run_frame("R8 single-byte all-call", 1, 1'b1);
        clear_cap();
        tx[0] = 8'hFE; tx[1] = 8'h00; tx[2] = 8'h12;
        run_frame("R8 all-call ignores second byte", 3, 1'b1);
        cfg_a2_en = 1'b0;
        clear_cap();
        tx[0] = 8'hFE; tx[1] = 8'h00;
        run_frame("R9 all-call needs both enables", 2, 1'b0);
    endtask

    task automatic t_short();
        cfg_a2_en = 1'b1;
        clear_cap();
        tx[0] = 8'hAC;
        run_frame("R11 frame too short", 1, 1'b0);
    endtask

    task automatic t_restart();
        clear_cap();
        send_byte(8'hAC, 1'b1, 1'b0);
        tx[0] = 8'hFF; tx[1] = 8'h77;
        run_frame("R12 restart drops held byte", 2, 1'b1);
    endtask

    initial begin
        t_reset();
        t_bypass();
        t_six_bit();
        t_seven_bit();
        t_a1_off();
        t_second_byte();
        t_allcall();
        t_short();
        t_restart();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule